// File: doc/BRIEF.md
# Diode-Matrix Key Scanner

This block reads a diode-isolated key matrix of up to 32 switches. It does not drive any row lines of its own. Instead it reuses the common-cathode strobes of a multiplexed LED display as row drivers. While the display multiplexer holds a digit slot active, any pressed switch on that digit's row pulls its pulled-up key return line low. The display scanner supplies the active digit index and a one-cycle strobe at the end of each slot. At each strobe this block samples the four key return lines, after a two-flop synchroniser, and credits the sample to the row being strobed.

Each key has its own debounce cell. The reported state of a key changes only after two consecutive samples of its row agree with each other and differ from the reported state. The row is revisited once per display frame, so the debounce time follows the multiplex clock. Rows beyond the display scan limit are never sampled, and neither are return lines whose enable bit is clear. Disabled lines are handed back to general-purpose use. The fifth port becomes the interrupt line as soon as any return line is enabled.

An active-low interrupt output falls on any change to the debounced key state. It stays low until the host issues a read/clear request.

Top module: `keymatrix_scan`

## Requirements
- R1: After reset, key_state_o is all zero and irq_n_o is high.
- R2: A sample is taken only on a cycle where slot_end_i is high. The sample is credited to row digit_idx_i. Line l of row r maps to key_state_o bit r*4+l. A low level on a key line means pressed, and a bit value of 1 means pressed. key_n_i must be stable for two clock cycles before the strobe. The new state is visible on the cycle after the strobe.
- R3: scan_limit_i holds the index of the highest scanned row, so n digits are encoded as n-1. Strobes for rows above it change no key state.
- R4: Keys on a line whose key_en_i bit is 0 are never updated.
- R5: A key becomes pressed only after two consecutive samples of its row read low. A single low sample that is followed by a high sample leaves it released.
- R6: A key becomes released only after two consecutive samples of its row read high.
- R7: irq_n_o goes low on the cycle after any debounced key bit changes. It stays low until a read/clear request is made.
- R8: rd_clr_i sets irq_n_o high on the next cycle. If a key change happens in the same cycle as rd_clr_i, the change takes priority and irq_n_o stays low.
- R9: gpio_rel_o[3:0] is the inverse of key_en_i. gpio_rel_o[4] is 1 only when no key line is enabled, because otherwise the fifth port serves as the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| digit_idx_i | input | 3 | Row (digit) currently strobed by the display multiplexer |
| slot_end_i | input | 1 | One-cycle strobe at the end of a digit slot |
| scan_limit_i | input | 3 | Highest scanned row index |
| key_en_i | input | 4 | Per-line enable for key scanning |
| key_n_i | input | 4 | Asynchronous key return line levels, active low |
| rd_clr_i | input | 1 | Read/clear request for the interrupt |
| key_state_o | output | 32 | Debounced key state, one bit per key |
| irq_n_o | output | 1 | Active-low key change interrupt |
| gpio_rel_o | output | 5 | Ports released to general-purpose use |

## Verification
The hardest condition to reach from the ports is the boundary of the two-sample debounce. A key that reads low on exactly one frame and high on the next must never be reported. This has to hold while other rows are still settling, and while the scan limit and line enables change between frames. The bench drives whole frames of all eight row strobes. It sweeps several scan limits and enable masks, and it holds each key pattern for one frame or for two. It also places one strobe that causes a change in the same cycle as a read/clear request, to check which of the two takes effect.

// File: rtl/km_pkg.sv
package km_pkg;
  localparam int unsigned KM_ROWS  = 8;
  localparam int unsigned KM_LINES = 4;
endpackage

// File: rtl/km_sync.sv
module km_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  // idle level of a pulled-up line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/km_row_sel.sv
module km_row_sel #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned LINES = 4,
  parameter int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned KEYS = ROWS * LINES
) (
  input  logic             slot_end_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] lim_i,
  input  logic [LINES-1:0] en_i,
  output logic [KEYS-1:0]  upd_o
);
  logic row_ok;
  assign row_ok = slot_end_i && (row_i <= lim_i);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit = row_ok && (row_i == ROW_W'(r));
    for (genvar l = 0; l < LINES; l++) begin : g_line
      assign upd_o[r*LINES+l] = hit && en_i[l];
    end
  end
endmodule

// File: rtl/km_key_cell.sv
module km_key_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic raw_i,
  output logic state_o,
  output logic chg_o
);
  logic prev_q, state_q;

  // two agreeing samples that differ from the reported value
  assign chg_o = upd_i && (raw_i == prev_q) && (raw_i != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      state_q <= 1'b0;
    end else if (upd_i) begin
      prev_q <= raw_i;
      if (chg_o) state_q <= raw_i;
    end
  end
  assign state_o = state_q;
endmodule

// File: rtl/keymatrix_scan.sv
module keymatrix_scan #(
  parameter int unsigned ROWS  = km_pkg::KM_ROWS,
  parameter int unsigned LINES = km_pkg::KM_LINES,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned KEYS  = ROWS * LINES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] digit_idx_i,
  input  logic             slot_end_i,
  input  logic [ROW_W-1:0] scan_limit_i,
  input  logic [LINES-1:0] key_en_i,
  input  logic [LINES-1:0] key_n_i,
  input  logic             rd_clr_i,
  output logic [KEYS-1:0]  key_state_o,
  output logic             irq_n_o,
  output logic [LINES:0]   gpio_rel_o
);
  logic [LINES-1:0] lvl_n;
  logic [KEYS-1:0]  upd, chg;
  logic             irq_q;

  km_sync #(.W(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (key_n_i),
    .q_o   (lvl_n)
  );

  km_row_sel #(.ROWS(ROWS), .LINES(LINES), .ROW_W(ROW_W)) u_row_sel (
    .slot_end_i(slot_end_i),
    .row_i     (digit_idx_i),
    .lim_i     (scan_limit_i),
    .en_i      (key_en_i),
    .upd_o     (upd)
  );

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    km_key_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd[k]),
      .raw_i  (~lvl_n[k % LINES]),
      .state_o(key_state_o[k]),
      .chg_o  (chg[k])
    );
  end

  // a change wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (|chg)     irq_q <= 1'b1;
    else if (rd_clr_i) irq_q <= 1'b0;
  end

  assign irq_n_o    = ~irq_q;
  assign gpio_rel_o = {~|key_en_i, ~key_en_i};
endmodule

// File: rtl/keymatrix_scan_chk.sv
module keymatrix_scan_chk #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned LINES = 4,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned KEYS  = ROWS * LINES
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ROW_W-1:0] digit_idx_i,
  input logic             slot_end_i,
  input logic [ROW_W-1:0] scan_limit_i,
  input logic             rd_clr_i,
  input logic [KEYS-1:0]  key_state_o,
  input logic             irq_n_o
);
  AST_NO_STROBE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> $stable(key_state_o)); // R2
  AST_ROW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_i && (digit_idx_i > scan_limit_i)) |=> $stable(key_state_o)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_n_o) |-> (key_state_o != $past(key_state_o))); // R7
  AST_CHANGE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(key_state_o) |-> !irq_n_o); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_n_o && !rd_clr_i) |=> !irq_n_o); // R7
  AST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !slot_end_i) |=> irq_n_o); // R8
endmodule

bind keymatrix_scan keymatrix_scan_chk #(.ROWS(ROWS), .LINES(LINES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .digit_idx_i (digit_idx_i),
  .slot_end_i  (slot_end_i),
  .scan_limit_i(scan_limit_i),
  .rd_clr_i    (rd_clr_i),
  .key_state_o (key_state_o),
  .irq_n_o     (irq_n_o)
);

// File: tb/keymatrix_scan_bench.sv
`timescale 1ns/1ps
module keymatrix_scan_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  digit_idx_i = '0;
  logic        slot_end_i = 1'b0;
  logic [2:0]  scan_limit_i = 3'd7;
  logic [3:0]  key_en_i = '0;
  logic [3:0]  key_n_i = '1;
  logic        rd_clr_i = 1'b0;
  logic [31:0] key_state_o;
  logic        irq_n_o;
  logic [4:0]  gpio_rel_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] m_st = '0, m_prev = '0;
  logic        m_pend = 1'b0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  keymatrix_scan u_keymatrix_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .digit_idx_i(digit_idx_i),
    .slot_end_i(slot_end_i), .scan_limit_i(scan_limit_i), .key_en_i(key_en_i),
    .key_n_i(key_n_i), .rd_clr_i(rd_clr_i), .key_state_o(key_state_o),
    .irq_n_o(irq_n_o), .gpio_rel_o(gpio_rel_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one digit slot: levels, settle through synchroniser, strobe
  task automatic slot(int row, logic [3:0] lvl, bit clr);
    bit chg = 1'b0;
    @(negedge clk_i);
    digit_idx_i = 3'(row);
    key_n_i = lvl;
    repeat (3) @(negedge clk_i);
    slot_end_i = 1'b1;
    rd_clr_i = clr;
    // model: R2 R3 R4 R5 R6
    if (row <= int'(scan_limit_i)) begin
      for (int l = 0; l < 4; l++) begin
        if (key_en_i[l]) begin
          int k = row * 4 + l;
          logic raw = ~lvl[l];
          if (raw == m_prev[k] && raw != m_st[k]) begin
            m_st[k] = raw;
            chg = 1'b1;
          end
          m_prev[k] = raw;
        end
      end
    end
    if (chg) m_pend = 1'b1;
    else if (clr) m_pend = 1'b0;
    @(negedge clk_i);
    slot_end_i = 1'b0;
    rd_clr_i = 1'b0;
  endtask

  function automatic logic [3:0] pat(int row, int p, int seed);
    logic [3:0] v;
    for (int l = 0; l < 4; l++)
      v[l] = !((((row * 4 + l) * 7 + p * 3 + seed) % 5) < 2);
    return v;
  endfunction

  task automatic frame(int p, int seed);
    for (int r = 0; r < 8; r++) slot(r, pat(r, p, seed), 1'b0);
  endtask

  task automatic clear_irq();
    @(negedge clk_i);
    rd_clr_i = 1'b1;
    m_pend = 1'b0;
    @(negedge clk_i);
    rd_clr_i = 1'b0;
    check("R8 clear", {31'd0, irq_n_o}, 32'd1);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 state", key_state_o, 32'd0);
    check("R1 irq", {31'd0, irq_n_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 none", {27'd0, gpio_rel_o}, 32'h1f);

    // R5: single low frame is rejected
    key_en_i = 4'hf;
    slot(1, 4'b1101, 1'b0);
    slot(1, 4'b1111, 1'b0);
    check("R5 glitch", key_state_o, 32'd0);
    check("R5 no irq", {31'd0, irq_n_o}, 32'd1);
    slot(1, 4'b1101, 1'b0);
    slot(1, 4'b1101, 1'b0);
    check("R5 press", key_state_o, 32'h0000_0020);
    check("R7 irq", {31'd0, irq_n_o}, 32'd0);
    slot(1, 4'b1111, 1'b0);
    check("R6 one high", key_state_o, 32'h0000_0020);
    // R8: change in the same cycle as clear keeps irq low
    slot(1, 4'b1111, 1'b1);
    check("R6 release", key_state_o, 32'd0);
    check("R8 change wins", {31'd0, irq_n_o}, 32'd0);
    clear_irq();

    // sweep limits, enables and patterns
    for (int c = 0; c < 6; c++) begin
      logic [2:0] lims[6] = '{3'd7, 3'd3, 3'd0, 3'd5, 3'd7, 3'd1};
      logic [3:0] ens[6]  = '{4'hf, 4'hf, 4'h5, 4'hf, 4'h2, 4'hc};
      scan_limit_i = lims[c];
      key_en_i = ens[c];
      @(negedge clk_i);
      check($sformatf("R9 rel c%0d", c), {27'd0, gpio_rel_o},
            {27'd0, (ens[c] == 4'h0), ~ens[c]});
      for (int p = 0; p < 4; p++) begin
        frame(p, c);
        check($sformatf("R3 R4 R5 single c%0d p%0d", c, p), key_state_o, m_st);
        frame(p, c);
        check($sformatf("R2 R3 R4 R6 double c%0d p%0d", c, p), key_state_o, m_st);
        check($sformatf("R7 irq c%0d p%0d", c, p), {31'd0, irq_n_o}, {31'd0, ~m_pend});
        if (p == 2) clear_irq();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule